// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous static memory with registered inputs and a registered read path. The address, the control inputs and the write data are all captured on the rising clock edge. Read data is held in an output register, so the first read data appears one clock after its address is taken. Each word is built from byte lanes of nine bits: eight data bits plus one parity bit. The default word is four lanes (36 bits), and the lane count is a parameter, so a two-lane 18-bit build is also available.

An access starts on one of two address strobes: a processor strobe or a controller strobe. Once started, the access can continue as a four-beat burst. The only input needed to move to the next beat is an advance signal, and the low two address bits then follow a linear or an interleaved sequence. Writes use three levels of control: a global write that covers every lane, a byte-write enable, and one select per lane. Three chip-select inputs are sampled at the strobes. Output enable and a sleep input act on the output at once, without waiting for a clock edge.

Top module: `psb_sram`

## Requirements
- R1: A word written through any write path is returned unchanged by a later read of the same address. The word is made of LANES lanes of LANE_W bits, and lane i occupies bits [LANE_W*i+LANE_W-1 : LANE_W*i].
- R2: A read taken at clock edge N is not visible after edge N. It appears on `dq_out` with `dq_oe` high after edge N+1.
- R3: After an access starts, each following edge with both strobes inactive and `adv_n` low moves to the next beat. One start address gives four beats, and the fifth beat wraps back to the first. An edge with `adv_n` high repeats the current beat.
- R4: Beat k (k = 0..3) of a burst keeps every address bit above bit 1. Its two low bits are (start + k) mod 4 when `burst_linear` is 1, and start XOR k when `burst_linear` is 0.
- R5: When `adsp_n` and `ce_n` are both low, the processor strobe takes priority over `adsc_n`, and the cycle it starts is always a read, whatever the write controls are. A controller-strobe start takes its read or write from the write controls.
- R6: A processor strobe that arrives while `ce_n` is high is ignored. An idle block stays idle, and a running burst continues as if no strobe had been presented.
- R7: `gw_n` low writes all lanes. With `gw_n` high and `bwe_n` low, only the lanes whose `bw_n[i]` is low are written, and bit i of `bw_n` selects lane i. With both `gw_n` and `bwe_n` high, the cycle is a read and nothing is written. The same rules apply to burst beats after the first.
- R8: The block is selected only when `ce_n` is low, `cs_hi` is high and `cs_lo_n` is low. A strobe taken while the block is not selected ends the access. Data from the cycle before that strobe is still driven for one cycle, and `dq_oe` is low after the following edge.
- R9: While `zz` is high, `dq_oe` is low at once, no edge writes the memory or starts an access, and any running burst is dropped. Stored words are kept.
- R10: `oe_n` high forces `dq_oe` low at once without disturbing the read pipeline. When `oe_n` returns low, the pending read data is driven.
- R11: A write taken at edge N leaves `dq_oe` low after edge N+1.
- R12: After reset, `dq_oe` is low and stays low until a read is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, taken at a strobe |
| wdata | input | LANES*LANE_W | Write data |
| burst_linear | input | 1 | 1: linear beat order, 0: interleaved |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write (all lanes), active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| zz | input | 1 | Sleep, asynchronous, active high |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | High when dq_out drives the bus, low means tri-stated |

## Verification
The bench builds the block with ADDR_W = 5, so there are 32 words of four 9-bit lanes. This small depth lets it write and then read back every address, and start a burst at every one of the 32 addresses in both beat orders, which covers all four low-bit start positions in every upper-address group. Because the lane count stays at four, all sixteen byte-select masks can be tried against a known background. The remaining cases are run directly with expected words computed in the bench: strobe priority, deselect timing, sleep and output-enable behaviour.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        STB_NONE = 2'd0,
        STB_PROC = 2'd1,
        STB_CTRL = 2'd2
    } strobe_e;

    typedef struct packed {
        logic  active;
        beat_t step;
    } burst_t;

    // Pick the strobe that starts a cycle: processor strobe counts only
    // with chip enable low, and then wins over the controller strobe.
    function automatic strobe_e pick_strobe(input logic adsp_n,
                                            input logic adsc_n,
                                            input logic ce_n);
        if (!adsp_n && !ce_n)
            return STB_PROC;
        else if (!adsc_n)
            return STB_CTRL;
        else
            return STB_NONE;
    endfunction

    // Low address bits of a burst beat.
    function automatic beat_t beat_low(input beat_t start,
                                       input beat_t step,
                                       input logic  linear);
        return linear ? beat_t'(start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zz,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_linear,
    input  logic [ADDR_W-1:0] addr,
    output cyc_e              kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  lane_we
);

    burst_t            bs, bs_nxt;
    logic [ADDR_W-1:0] base, base_nxt;
    strobe_e           strobe;
    logic              selected;
    logic              wr_req;
    logic [LANES-1:0]  wr_lanes;

    always_comb begin
        strobe   = pick_strobe(adsp_n, adsc_n, ce_n);
        selected = !ce_n && cs_hi && !cs_lo_n;
        wr_req   = !gw_n || !bwe_n;
        wr_lanes = gw_n ? ~bw_n : {LANES{1'b1}};

        bs_nxt   = bs;
        base_nxt = base;
        kind     = CYC_NONE;
        acc_addr = base;

        if (zz) begin
            bs_nxt.active = 1'b0;
        end else if (strobe != STB_NONE) begin
            if (selected) begin
                bs_nxt.active = 1'b1;
                bs_nxt.step   = '0;
                base_nxt      = addr;
                acc_addr      = addr;
                kind          = (strobe == STB_PROC || !wr_req) ? CYC_READ : CYC_WRITE;
            end else begin
                bs_nxt.active = 1'b0;
            end
        end else if (bs.active) begin
            if (!adv_n)
                bs_nxt.step = beat_t'(bs.step + 1'b1);
            acc_addr = {base[ADDR_W-1:BEAT_W],
                        beat_low(base[BEAT_W-1:0], bs_nxt.step, burst_linear)};
            kind     = wr_req ? CYC_WRITE : CYC_READ;
        end

        lane_we = (kind == CYC_WRITE) ? wr_lanes : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bs   <= '0;
            base <= '0;
        end else begin
            bs   <= bs_nxt;
            base <= base_nxt;
        end
    end

    // R3: an advance edge inside a burst moves exactly one beat
    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (!zz && adsp_n && adsc_n && bs.active && !adv_n)
        |=> (bs.active && bs.step == beat_t'($past(bs.step) + 2'd1)));

    // R3: without advance the beat is repeated
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!zz && adsp_n && adsc_n && bs.active && adv_n)
        |=> (bs.active && $stable(bs.step) && $stable(base)));

    // R6: a processor strobe with chip enable high starts nothing
    a_r6_proc_ignored: assert property (@(posedge clk) disable iff (rst)
        (!zz && !adsp_n && ce_n && adsc_n && !bs.active) |=> !bs.active);

    // R9: sleep drops any access in progress
    a_r9_sleep_drop: assert property (@(posedge clk) disable iff (rst)
        zz |=> !bs.active);

endmodule

// File: rtl/psb_array.sv
module psb_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_q
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (lane_we[l])
                store[wr_addr] <= wdata[l*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (rd_en)
                q <= store[rd_addr];
        end

        assign rd_q[l*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/psb_sram.sv
module psb_sram
    import psb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              burst_linear,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              zz,
    output logic [WORD_W-1:0] dq_out,
    output logic              dq_oe
);

    cyc_e              kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  lane_we;

    logic              rd_a;
    logic [ADDR_W-1:0] addr_a;
    logic              drv_b;

    psb_ctrl #(
        .ADDR_W(ADDR_W),
        .LANES (LANES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .zz          (zz),
        .adsp_n      (adsp_n),
        .adsc_n      (adsc_n),
        .adv_n       (adv_n),
        .ce_n        (ce_n),
        .cs_hi       (cs_hi),
        .cs_lo_n     (cs_lo_n),
        .gw_n        (gw_n),
        .bwe_n       (bwe_n),
        .bw_n        (bw_n),
        .burst_linear(burst_linear),
        .addr        (addr),
        .kind        (kind),
        .acc_addr    (acc_addr),
        .lane_we     (lane_we)
    );

    // Address stage: remember which word the sampled read wants.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_a   <= 1'b0;
            addr_a <= '0;
            drv_b  <= 1'b0;
        end else begin
            rd_a   <= (kind == CYC_READ);
            addr_a <= acc_addr;
            drv_b  <= rd_a;
        end
    end

    psb_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .lane_we(lane_we),
        .wr_addr(acc_addr),
        .wdata  (wdata),
        .rd_en  (rd_a),
        .rd_addr(addr_a),
        .rd_q   (dq_out)
    );

    assign dq_oe = drv_b && !oe_n && !zz;

    // R8: a deselecting strobe stops the output after the next edge
    a_r8_single_desel: assert property (@(posedge clk) disable iff (rst)
        (!zz && !adsc_n && !cs_hi) |=> ##1 !dq_oe);

    // R11: a controller write leaves the bus undriven one edge later
    a_r11_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (!zz && adsp_n && !adsc_n && !ce_n && cs_hi && !cs_lo_n && !gw_n)
        |=> ##1 !dq_oe);

    // R9: sleep writes nothing into the array
    a_r9_sleep_nowrite: assert property (@(posedge clk) disable iff (rst)
        zz |-> (lane_we == '0));

endmodule

// File: tb/sim_psb_sram.sv
`timescale 1ns/100ps
module sim_psb_sram;

    localparam int AW     = 5;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int W      = LANES * LANE_W;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic          burst_linear;
    logic          adsp_n, adsc_n, adv_n, ce_n, cs_hi, cs_lo_n;
    logic          gw_n, bwe_n, oe_n, zz;
    logic [LANES-1:0] bw_n;
    logic [W-1:0]  dq_out;
    logic          dq_oe;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic done  = 1'b0;
    logic [W-1:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    psb_sram #(.ADDR_W(AW), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .burst_linear(burst_linear), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [W-1:0] pat(input int a, input int salt);
        return W'(a) * 36'h0_1357_9BDF + W'(salt) * 36'h2_4680_0AC1 + 36'h3;
    endfunction

    function automatic logic [AW-1:0] baddr(input int s, input int k, input logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(s + k) : (2'(s) ^ 2'(k));
        return {AW'(s) >> 2, lo};
    endfunction

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
        oe_n = 1'b0; zz = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [W-1:0] exp);
        chk({req, " drive"}, W'(dq_oe), W'(1));
        chk({req, " data"}, dq_out, exp);
    endtask

    task automatic chk_off(input string req);
        chk({req, " off"}, W'(dq_oe), W'(0));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1; burst_linear = 1'b1; addr = '0; wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        chk_off("R12 reset");
        tick(); tick();
        chk_off("R12 idle");

        // R1: fill every word with controller-strobe global writes
        for (int a = 0; a < DEPTH; a++) begin
            adsc_n = 1'b0; addr = AW'(a); gw_n = 1'b0; wdata = pat(a, 0);
            exp_mem[a] = pat(a, 0);
            tick();
        end
        idle();
        tick();
        chk_off("R11 after write");
        tick();
        chk_rd("R1 last word", exp_mem[DEPTH-1]);

        // R2: first data one edge late
        adsc_n = 1'b0; cs_hi = 1'b0; tick(); idle(); tick(); tick();
        adsc_n = 1'b0; addr = AW'(17); tick(); idle();
        chk_off("R2 not early");
        tick();
        chk_rd("R2 latency", exp_mem[17]);

        // R1: back-to-back reads of every word
        for (int a = 0; a < DEPTH; a++) begin
            adsc_n = 1'b0; addr = AW'(a);
            tick();
            if (a > 0) chk_rd($sformatf("R1 word %0d", a - 1), exp_mem[a-1]);
        end
        idle(); tick();
        chk_rd("R1 final word", exp_mem[DEPTH-1]);

        // R3 R4: bursts from every start in both orders
        for (int lin = 0; lin < 2; lin++) begin
            for (int s = 0; s < DEPTH; s++) begin
                idle();
                burst_linear = lin[0];
                if (s % 2 == 1) adsc_n = 1'b0; else adsp_n = 1'b0;
                addr = AW'(s);
                tick();
                adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b0;
                for (int k = 0; k < 5; k++) begin
                    tick();
                    chk_rd($sformatf("R3 R4 lin %0d start %0d beat %0d", lin, s, k),
                           exp_mem[baddr(s, k, lin[0])]);
                end
                adv_n = 1'b1;
                tick(); tick();
                chk_rd($sformatf("R3 hold start %0d", s), exp_mem[baddr(s, 1, lin[0])]);
            end
        end
        idle(); burst_linear = 1'b1;

        // R7: every lane mask
        for (int m = 0; m < 16; m++) begin
            adsc_n = 1'b0; addr = AW'(m); bwe_n = 1'b0; bw_n = ~4'(m); wdata = pat(m, 7);
            for (int l = 0; l < LANES; l++)
                if (m[l]) exp_mem[m][l*LANE_W +: LANE_W] = pat(m, 7) >> (l*LANE_W);
            tick(); idle();
            adsc_n = 1'b0; addr = AW'(m); tick(); idle(); tick();
            chk_rd($sformatf("R7 mask %0d", m), exp_mem[m]);
        end

        // R7: global write overrides the lane selects
        adsc_n = 1'b0; addr = AW'(20); gw_n = 1'b0; bwe_n = 1'b0; bw_n = '1;
        wdata = pat(20, 9); exp_mem[20] = pat(20, 9);
        tick(); idle();
        adsc_n = 1'b0; addr = AW'(20); tick(); idle(); tick();
        chk_rd("R7 global", exp_mem[20]);

        // R7: byte enable high means no write
        adsc_n = 1'b0; addr = AW'(21); bw_n = '0; wdata = pat(21, 11);
        tick(); idle(); tick();
        chk_rd("R7 no write", exp_mem[21]);
        tick();
        chk_rd("R7 no write again", exp_mem[21]);

        // R5: processor start is a read; the next beat can write
        adsp_n = 1'b0; addr = AW'(8); gw_n = 1'b0; wdata = pat(8, 13);
        tick();
        adsp_n = 1'b1; adv_n = 1'b0; gw_n = 1'b0; wdata = pat(9, 13);
        exp_mem[9] = pat(9, 13);
        tick();
        chk_rd("R5 proc read", exp_mem[8]);
        idle(); tick();
        chk_off("R11 burst write");
        tick();
        chk_rd("R7 burst write", exp_mem[9]);

        // R5: both strobes low, processor wins
        adsp_n = 1'b0; adsc_n = 1'b0; addr = AW'(3); gw_n = 1'b0; wdata = ~pat(3, 0);
        tick(); idle(); tick();
        chk_rd("R5 priority", exp_mem[3]);
        adsc_n = 1'b0; addr = AW'(3); tick(); idle(); tick();
        chk_rd("R5 unchanged", exp_mem[3]);

        // R6: processor strobe with chip enable high, from idle
        adsc_n = 1'b0; cs_hi = 1'b0; tick(); idle(); tick(); tick();
        adsp_n = 1'b0; ce_n = 1'b1; addr = AW'(4); tick(); idle(); tick();
        chk_off("R6 idle");
        tick();
        chk_off("R6 idle later");

        // R6: same strobe during a burst
        adsc_n = 1'b0; addr = AW'(12); tick(); idle();
        adsp_n = 1'b0; ce_n = 1'b1; addr = AW'(20); adv_n = 1'b0; tick(); idle();
        chk_rd("R6 burst beat0", exp_mem[12]);
        tick();
        chk_rd("R6 burst beat1", exp_mem[13]);

        // R8: each select input, single-cycle deselect
        for (int v = 0; v < 3; v++) begin
            idle();
            adsc_n = 1'b0; addr = AW'(6); tick(); idle(); tick();
            chk_rd("R8 before", exp_mem[6]);
            adsc_n = 1'b0;
            if (v == 0) ce_n = 1'b1; else if (v == 1) cs_hi = 1'b0; else cs_lo_n = 1'b1;
            tick(); idle();
            chk_rd($sformatf("R8 variant %0d one more", v), exp_mem[6]);
            tick();
            chk_off($sformatf("R8 variant %0d", v));
        end

        // R9: sleep
        adsc_n = 1'b0; addr = AW'(7); tick(); idle(); tick();
        chk_rd("R9 before", exp_mem[7]);
        zz = 1'b1; #0.5;
        chk_off("R9 async");
        adsc_n = 1'b0; addr = AW'(7); gw_n = 1'b0; wdata = ~pat(7, 5);
        tick(); tick();
        chk_off("R9 asleep");
        idle(); tick(); tick();
        chk_off("R9 burst dropped");
        adsc_n = 1'b0; addr = AW'(7); tick(); idle(); tick();
        chk_rd("R9 contents kept", exp_mem[7]);

        // R10: output enable
        adsc_n = 1'b0; addr = AW'(10); tick(); idle(); tick();
        chk_rd("R10 on", exp_mem[10]);
        oe_n = 1'b1; #0.5;
        chk_off("R10 async");
        tick();
        chk_off("R10 held");
        oe_n = 1'b0; #0.5;
        chk_rd("R10 resume", exp_mem[10]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule